// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves data between memory and a single peripheral. It has two buffer slots, A and B. Each slot holds a start address and a byte count. Software loads one slot while the engine drains the other. When the active slot runs out, the engine marks that slot done. If the other slot has been started, the engine moves on to it without a gap in service, and a buffer-in-use bit in the status word shows which slot is being served.

Software controls the channel through a 32-byte register window. The control/status byte has three views: a set view, where each 1 written sets a bit; a clear view, where each 1 written clears a bit; and a plain read view. A configuration register selects the transfer direction, the byte order, the burst length, the data width and which of sixteen peripheral request lines is used. The peripheral asks for a burst with a request level. The engine then issues one memory access per beat and acknowledges the peripheral on the last beat of the burst. The interrupt output reports completion and errors, and software acknowledges it through the clear view.

Top module: `dbdma_chan`

## Requirements
- R1: After reset the status byte reads 0x00 (slot A in use), the configuration register reads 0x00 and `irq_o` is low.
- R2: Register offsets are: configuration 0x00, set view 0x04, clear view 0x08, status read 0x0C, slot A address/count 0x10/0x14, slot B address/count 0x18/0x1C. In the status byte, bit0 is run, bit1 interrupt enable, bit2 error, bit3 done A, bit4 start A, bit5 done B, bit6 start B and bit7 buffer-in-use (0 = A, 1 = B). A 1 written to the set view sets the matching bit of bits 6:0, and a 1 written to the clear view clears it. A 0 written to either view has no effect, and bit7 ignores both views.
- R3: The configuration register keeps the low 8 bits of a write: bit0 direction, bit1 big-endian, bit2 burst of 8 (else 4), bit3 16-bit width (else 8-bit), bits 7:4 request source, which is driven on `per_sel_o`. A count register keeps 13 bits, so writing 0xFFFFF reads back 0x1FFF.
- R4: When the served slot's last beat completes, that slot's start bit clears and its done bit sets. The buffer-in-use bit flips in the same edge only if the other slot's start bit is set.
- R5: When the engine is between bursts, the served slot is not started and the other slot is started, the buffer-in-use bit flips to the other slot.
- R6: Each beat adds the beat size (1 byte, or 2 bytes in 16-bit mode) to the served slot's address and subtracts it from the count, floored at 0. Reading the address register therefore gives the current position. 8-bit beats carry bits 7:0 with the upper byte 0, and big-endian 16-bit beats swap the two bytes.
- R7: With bit0 of the configuration register at 1, beats write peripheral data to memory (`mem_we_o` = 1). With bit0 at 0, beats read memory into `per_wdata_o`.
- R8: A high `per_req_i` starts a burst of 4 or 8 beats. The burst ends early at the end of the slot. `per_ack_o` pulses on the burst's last beat.
- R9: `irq_o` is high while interrupt enable is set and any of error, done A or done B is set. Clearing those bits through the clear view drops it.
- R10: While run is 0 no memory access is issued. Setting run again resumes the transfer from the kept slot position, start bits and counts.
- R11: Setting a start bit for a slot whose count is 0 or whose address has a nonzero bit 1:0 sets error, clears run and leaves that start bit clear. No memory access follows.
- R12: Writes to a slot's address or count register are ignored while that slot's start bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte offset, bits 4:2 |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| mem_req_o | output | 1 | Memory access request, one beat |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 32 | Beat byte address |
| mem_wdata_o | output | 16 | Write data to memory |
| mem_rdata_i | input | 16 | Read data from memory |
| mem_gnt_i | input | 1 | Memory accepts the beat in this cycle |
| per_req_i | input | 1 | Peripheral is ready for a burst |
| per_ack_o | output | 1 | Last beat of a burst done |
| per_sel_o | output | 4 | Selected peripheral request source |
| per_wdata_o | output | 16 | Data to the peripheral |
| per_rdata_i | input | 16 | Data from the peripheral |
| irq_o | output | 1 | Channel interrupt |

## Verification
A register write takes effect at the edge that samples it, so the status byte and the register readback are checked from the next falling edge. A burst starts at the edge after a started slot sees `per_req_i`. Its first memory request is visible in the following cycle, and there is one idle cycle between bursts. Done, error and `irq_o` change at the edge of the final beat or of the rejecting write. The memory monitor compares every granted beat, at the falling edge before the beat's own rising edge, against an expected-beat queue that the driver fills. Status is polled at falling edges with a timeout, and pauses are held for ten cycles, within which any beat counts as a failure.

// File: rtl/dbdma_pkg.sv
`timescale 1ns/1ps
package dbdma_pkg;
  localparam int unsigned ST_W       = 8;
  localparam int unsigned ST_RUN     = 0;
  localparam int unsigned ST_IE      = 1;
  localparam int unsigned ST_ERR     = 2;
  localparam int unsigned ST_DONE_A  = 3;
  localparam int unsigned ST_START_A = 4;
  localparam int unsigned ST_DONE_B  = 5;
  localparam int unsigned ST_START_B = 6;
  localparam int unsigned ST_BIU     = 7;

  typedef struct packed {
    logic [3:0] src;
    logic       wide;
    logic       burst8;
    logic       big;
    logic       to_mem;
  } cfg_t;

  typedef enum logic [2:0] {
    RG_CFG   = 3'd0,
    RG_SET   = 3'd1,
    RG_CLR   = 3'd2,
    RG_STAT  = 3'd3,
    RG_A_ADR = 3'd4,
    RG_A_CNT = 3'd5,
    RG_B_ADR = 3'd6,
    RG_B_CNT = 3'd7
  } reg_idx_e;

  function automatic int unsigned start_bit(input logic s);
    return s ? ST_START_B : ST_START_A;
  endfunction

  function automatic int unsigned done_bit(input logic s);
    return s ? ST_DONE_B : ST_DONE_A;
  endfunction
endpackage

// File: rtl/dbdma_slot.sv
`timescale 1ns/1ps
module dbdma_slot #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_adr_i,
  input  logic          wr_cnt_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          adv_i,
  input  logic [CW-1:0] step_i,
  output logic [AW-1:0] adr_o,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_o <= '0;
      cnt_o <= '0;
    end else if (adv_i) begin
      adr_o <= adr_o + AW'(step_i);
      cnt_o <= (cnt_o > step_i) ? cnt_o - step_i : '0;
    end else begin
      if (wr_adr_i) adr_o <= wdata_i;
      if (wr_cnt_i) cnt_o <= wdata_i[CW-1:0];
    end
  end

  AST_CNT_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (cnt_o < $past(cnt_o))); // R6
endmodule

// File: rtl/dbdma_ctrl.sv
`timescale 1ns/1ps
module dbdma_ctrl
  import dbdma_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_we_i,
  input  logic            clr_we_i,
  input  logic [ST_W-2:0] wdata_i,
  input  logic [1:0]      bad_i,
  input  logic            fin_i,
  input  logic            busy_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  logic [ST_W-1:0] stat_q, n;
  logic            rej, cur;

  always_comb begin
    n   = stat_q;
    rej = 1'b0;
    cur = stat_q[ST_BIU];
    if (set_we_i) begin
      n[ST_ERR:ST_RUN] = stat_q[ST_ERR:ST_RUN] | wdata_i[ST_ERR:ST_RUN];
      n[ST_DONE_A]     = stat_q[ST_DONE_A] | wdata_i[ST_DONE_A];
      n[ST_DONE_B]     = stat_q[ST_DONE_B] | wdata_i[ST_DONE_B];
      for (int k = 0; k < 2; k++) begin
        if (wdata_i[start_bit(1'(k))] && !stat_q[start_bit(1'(k))]) begin
          if (bad_i[k]) rej = 1'b1;
          else          n[start_bit(1'(k))] = 1'b1;
        end
      end
      if (rej) begin
        n[ST_ERR] = 1'b1;
        n[ST_RUN] = 1'b0;
      end
    end
    if (clr_we_i) n[ST_BIU-1:0] = n[ST_BIU-1:0] & ~wdata_i;
    // hardware events win over a same-cycle software write
    if (fin_i) begin
      n[start_bit(cur)] = 1'b0;
      n[done_bit(cur)]  = 1'b1;
      if (n[start_bit(!cur)]) n[ST_BIU] = !cur;
    end else if (!busy_i && !n[start_bit(cur)] && n[start_bit(!cur)]) begin
      n[ST_BIU] = !cur;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= n;
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q[ST_IE] &
                  (stat_q[ST_ERR] | stat_q[ST_DONE_A] | stat_q[ST_DONE_B]);

  AST_BIU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !fin_i) |=> $stable(stat_q[ST_BIU])); // R4
  AST_DONE_ON_FIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !stat_q[ST_BIU]) |=> (stat_q[ST_DONE_A] && !stat_q[ST_START_A])); // R4
  AST_REJECT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && wdata_i[ST_START_A] && !stat_q[ST_START_A] && bad_i[0])
    |=> (!stat_q[ST_RUN] && stat_q[ST_ERR] && !stat_q[ST_START_A])); // R11
endmodule

// File: rtl/dbdma_engine.sv
`timescale 1ns/1ps
module dbdma_engine #(
  parameter int unsigned CW   = 13,
  parameter int unsigned DW   = 16,
  parameter int unsigned MAXB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          big_i,
  input  logic          burst8_i,
  input  logic          to_mem_i,
  input  logic          run_i,
  input  logic          start_act_i,
  input  logic [CW-1:0] cnt_act_i,
  input  logic          per_req_i,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] per_rdata_i,
  output logic          busy_o,
  output logic          beat_o,
  output logic          fin_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          per_ack_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] per_wdata_o,
  output logic [CW-1:0] step_o
);
  localparam int unsigned BCW = $clog2(MAXB);
  localparam int unsigned HB  = DW / 2;

  logic           busy_q;
  logic [BCW-1:0] bcnt_q, blen_m1;
  logic           last_data;

  function automatic logic [DW-1:0] fmt(input logic [DW-1:0] x, input logic w, input logic b);
    if (!w)     return {{HB{1'b0}}, x[HB-1:0]};
    else if (b) return {x[HB-1:0], x[DW-1:HB]};
    else        return x;
  endfunction

  assign step_o      = wide_i ? CW'(2) : CW'(1);
  assign last_data   = cnt_act_i <= step_o;
  assign blen_m1     = burst8_i ? BCW'(MAXB - 1) : BCW'(MAXB / 2 - 1);
  assign mem_req_o   = busy_q & run_i & start_act_i;
  assign beat_o      = mem_req_o & mem_gnt_i;
  assign fin_o       = beat_o & last_data;
  assign per_ack_o   = beat_o & (last_data | (bcnt_q == blen_m1));
  assign busy_o      = busy_q;
  assign mem_we_o    = to_mem_i;
  assign mem_wdata_o = fmt(per_rdata_i, wide_i, big_i);
  assign per_wdata_o = fmt(mem_rdata_i, wide_i, big_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
    end else if (!busy_q) begin
      if (run_i && start_act_i && (cnt_act_i != '0) && per_req_i) begin
        busy_q <= 1'b1;
        bcnt_q <= '0;
      end
    end else if (!start_act_i || per_ack_o) begin
      busy_q <= 1'b0;
    end else if (beat_o) begin
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  AST_ACK_ENDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ack_o |=> !busy_q); // R8
endmodule

// File: rtl/dbdma_chan.sv
`timescale 1ns/1ps
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 13,
  parameter int unsigned DW   = 16,
  parameter int unsigned MAXB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [4:2]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_gnt_i,
  input  logic          per_req_i,
  output logic          per_ack_o,
  output logic [3:0]    per_sel_o,
  output logic [DW-1:0] per_wdata_o,
  input  logic [DW-1:0] per_rdata_i,
  output logic          irq_o
);
  localparam int unsigned NSLOT = 2;

  reg_idx_e        idx;
  cfg_t            cfg_q;
  logic [ST_W-1:0] stat;
  logic [AW-1:0]   adr [NSLOT];
  logic [CW-1:0]   cnt [NSLOT];
  logic [NSLOT-1:0] bad;
  logic            biu, busy, beat, fin;
  logic [CW-1:0]   step, cnt_act;

  assign idx     = reg_idx_e'(reg_addr_i);
  assign biu     = stat[ST_BIU];
  assign cnt_act = cnt[biu];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cfg_q <= '0;
    else if (reg_we_i && idx == RG_CFG)   cfg_q <= cfg_t'(reg_wdata_i[ST_W-1:0]);
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [2:0] ADR_IDX = 3'(4 + 2 * k);
    localparam logic [2:0] CNT_IDX = 3'(5 + 2 * k);
    logic wr_ok;
    assign wr_ok  = reg_we_i && !stat[start_bit(1'(k))];
    assign bad[k] = (adr[k][1:0] != 2'b00) || (cnt[k] == '0);
    dbdma_slot #(.AW(AW), .CW(CW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_adr_i (wr_ok && reg_addr_i == ADR_IDX),
      .wr_cnt_i (wr_ok && reg_addr_i == CNT_IDX),
      .wdata_i  (reg_wdata_i),
      .adv_i    (beat && (biu == 1'(k))),
      .step_i   (step),
      .adr_o    (adr[k]),
      .cnt_o    (cnt[k])
    );
  end

  dbdma_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (reg_we_i && idx == RG_SET),
    .clr_we_i (reg_we_i && idx == RG_CLR),
    .wdata_i  (reg_wdata_i[ST_W-2:0]),
    .bad_i    (bad),
    .fin_i    (fin),
    .busy_i   (busy),
    .stat_o   (stat),
    .irq_o    (irq_o)
  );

  dbdma_engine #(.CW(CW), .DW(DW), .MAXB(MAXB)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wide_i      (cfg_q.wide),
    .big_i       (cfg_q.big),
    .burst8_i    (cfg_q.burst8),
    .to_mem_i    (cfg_q.to_mem),
    .run_i       (stat[ST_RUN]),
    .start_act_i (stat[start_bit(biu)]),
    .cnt_act_i   (cnt_act),
    .per_req_i   (per_req_i),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rdata_i (mem_rdata_i),
    .per_rdata_i (per_rdata_i),
    .busy_o      (busy),
    .beat_o      (beat),
    .fin_o       (fin),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .per_ack_o   (per_ack_o),
    .mem_wdata_o (mem_wdata_o),
    .per_wdata_o (per_wdata_o),
    .step_o      (step)
  );

  assign mem_addr_o = adr[biu];
  assign per_sel_o  = cfg_q.src;

  always_comb begin
    case (idx)
      RG_CFG:   reg_rdata_o = AW'(cfg_q);
      RG_STAT:  reg_rdata_o = AW'(stat);
      RG_A_ADR: reg_rdata_o = adr[0];
      RG_A_CNT: reg_rdata_o = AW'(cnt[0]);
      RG_B_ADR: reg_rdata_o = adr[1];
      RG_B_CNT: reg_rdata_o = AW'(cnt[1]);
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_REQ_HAS_WORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (cnt_act != '0)); // R11
  AST_PAUSE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat[ST_RUN] |-> !mem_req_o); // R10
endmodule

// File: tb/sim_dbdma_chan.sv
`timescale 1ns/1ps
module sim_dbdma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:2]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, per_ack, irq;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, per_wdata;
  logic [15:0] per_rdata = 16'h1234;
  logic        per_req = 1'b0;
  logic [3:0]  per_sel;

  always #2.5 clk = ~clk;

  assign mem_gnt   = mem_req;
  assign mem_rdata = mem_addr[15:0] ^ 16'hA5C3;

  dbdma_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_gnt_i(mem_gnt), .per_req_i(per_req),
    .per_ack_o(per_ack), .per_sel_o(per_sel), .per_wdata_o(per_wdata),
    .per_rdata_i(per_rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] adr;
    logic        we;
    logic [15:0] dat;
  } beat_t;

  beat_t exp_q[$];
  int n_chk = 0, n_fail = 0, acks = 0, cyc = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [15:0] x, input logic w, input logic b);
    if (!w) return {8'h00, x[7:0]};
    return b ? {x[7:0], x[15:8]} : x;
  endfunction

  task automatic push_rd(input logic [31:0] base, input int n, input logic w, input logic b);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = base + (w ? 2 * i : i);
      exp_q.push_back('{adr: a, we: 1'b0, dat: fmt(a[15:0] ^ 16'hA5C3, w, b)});
    end
  endtask

  task automatic push_wr(input logic [31:0] base, input int n, input logic w, input logic b);
    for (int i = 0; i < n; i++)
      exp_q.push_back('{adr: base + (w ? 2 * i : i), we: 1'b1, dat: fmt(per_rdata, w, b)});
  endtask

  // monitor: a granted beat seen at the falling edge completes at the next rising edge
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt) begin
      if (exp_q.size() == 0) chk("R6 unexpected beat", mem_addr, 32'hFFFFFFFF);
      else begin
        beat_t e;
        e = exp_q.pop_front();
        chk("R6 beat address", mem_addr, e.adr);
        chk("R7 beat direction", 32'(mem_we), 32'(e.we));
        chk("R6 beat data", 32'(mem_we ? mem_wdata : per_wdata), 32'(e.dat));
      end
    end
    if (rst_n && per_ack) acks++;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_reg(input string r, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(r, d, exp);
  endtask

  task automatic wait_st(input logic [7:0] mask);
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      rd(3'd3, d);
      if ((d[7:0] & mask) == mask) return;
    end
    chk("R4 status timeout", d, 32'(mask));
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1 status", 3'd3, 32'h00);
    chk_reg("R1 config", 3'd0, 32'h00);
    chk("R1 irq", 32'(irq), 0);

    // R2 set/clear views
    wr(3'd1, 32'h02); chk_reg("R2 set ie", 3'd3, 32'h02);
    wr(3'd1, 32'h00); chk_reg("R2 zero set", 3'd3, 32'h02);
    wr(3'd2, 32'h00); chk_reg("R2 zero clear", 3'd3, 32'h02);
    wr(3'd2, 32'h02); chk_reg("R2 clear ie", 3'd3, 32'h00);

    // R3 config readback
    wr(3'd0, 32'h1A5); chk_reg("R3 config 8 bits", 3'd0, 32'hA5);

    // T4: 8-bit memory to peripheral, burst 4, 6 bytes
    acks = 0;
    wr(3'd0, 32'h50);
    chk("R3 per_sel", 32'(per_sel), 32'h5);
    wr(3'd4, 32'h100); wr(3'd5, 32'd6);
    push_rd(32'h100, 6, 1'b0, 1'b0);
    per_req = 1'b1;
    wr(3'd1, 32'h11);
    wait_st(8'h08);
    chk_reg("R4 done A, B idle keeps A", 3'd3, 32'h09);
    chk_reg("R6 address position", 3'd4, 32'h106);
    chk_reg("R6 count drained", 3'd5, 32'h0);
    chk("R8 acks burst 4", 32'(acks), 2);
    chk("R9 irq masked", 32'(irq), 0);
    wr(3'd1, 32'h02); chk("R9 irq raised", 32'(irq), 1);
    wr(3'd2, 32'h08); chk_reg("R9 ack done", 3'd3, 32'h03);
    chk("R9 irq dropped", 32'(irq), 0);

    // T5: 16-bit big-endian peripheral to memory, ping-pong A then B
    acks = 0;
    wr(3'd0, 32'h3B);
    wr(3'd4, 32'h200); wr(3'd5, 32'd4);
    wr(3'd6, 32'h300); wr(3'd7, 32'd2);
    push_wr(32'h200, 2, 1'b1, 1'b1);
    push_wr(32'h300, 1, 1'b1, 1'b1);
    wr(3'd1, 32'h50);
    wait_st(8'h20);
    chk_reg("R4 ping-pong both done biu B", 3'd3, 32'hAB);
    chk_reg("R6 16-bit step", 3'd4, 32'h204);
    chk("R8 acks at slot ends", 32'(acks), 2);
    chk("R9 irq done", 32'(irq), 1);
    wr(3'd2, 32'h28); chk_reg("R9 ack both", 3'd3, 32'h83);
    chk("R7 queue drained", 32'(exp_q.size()), 0);

    // T6: idle switch back to A, burst 8, 10 bytes
    acks = 0;
    wr(3'd0, 32'h04);
    wr(3'd4, 32'h400); wr(3'd5, 32'd10);
    push_rd(32'h400, 10, 1'b0, 1'b0);
    wr(3'd1, 32'h10);
    wait_st(8'h08);
    chk_reg("R5 switched to A and done", 3'd3, 32'h0B);
    chk("R8 acks burst 8", 32'(acks), 2);
    wr(3'd2, 32'h08);

    // T7: pause and resume, write-ignore while started
    per_req = 1'b0;
    wr(3'd0, 32'h00);
    wr(3'd4, 32'h500); wr(3'd5, 32'd4);
    wr(3'd2, 32'h01);
    wr(3'd1, 32'h10);
    chk_reg("R10 paused start kept", 3'd3, 32'h12);
    per_req = 1'b1;
    repeat (10) @(negedge clk);
    chk_reg("R10 count held in pause", 3'd5, 32'd4);
    wr(3'd4, 32'h900);
    chk_reg("R12 address write ignored", 3'd4, 32'h500);
    wr(3'd5, 32'd9);
    chk_reg("R12 count write ignored", 3'd5, 32'd4);
    push_rd(32'h500, 4, 1'b0, 1'b0);
    wr(3'd1, 32'h01);
    wait_st(8'h08);
    chk_reg("R10 resumed to done", 3'd3, 32'h0B);
    wr(3'd2, 32'h08);

    // T8: rejected starts
    wr(3'd1, 32'h10);
    chk_reg("R11 zero count rejected", 3'd3, 32'h06);
    chk("R11 irq on error", 32'(irq), 1);
    repeat (5) @(negedge clk);
    wr(3'd2, 32'h04); chk_reg("R11 error cleared", 3'd3, 32'h02);
    wr(3'd6, 32'h602); wr(3'd7, 32'd4);
    wr(3'd1, 32'h41);
    chk_reg("R11 misaligned rejected run cleared", 3'd3, 32'h06);
    repeat (5) @(negedge clk);
    wr(3'd1, 32'h80); chk_reg("R2 biu ignores set", 3'd3, 32'h06);
    wr(3'd2, 32'h00); chk_reg("R2 zero clear no effect", 3'd3, 32'h06);

    // T9: count width
    wr(3'd7, 32'hFFFFF);
    chk_reg("R3 count 13 bits", 3'd7, 32'h1FFF);
    chk_reg("R12 idle slot address writable", 3'd6, 32'h602);
    chk("R11 no stray beats", 32'(exp_q.size()), 0);

    rd(3'd3, d);
    finish_run();
  end
endmodule